// File: doc/BRIEF.md
# Tuner Control Register-File Serial Slave

This block is a two-wire serial (I2C-compatible) slave that gives a host controller access to the configuration and status registers of a tuner. It runs entirely on a fast system clock. SCL and SDA come in as plain inputs and are synchronised and glitch-filtered before any bus event is decoded. The only bus output is an open-drain pull-down enable for SDA. The pad and its pull-up lie outside the block.

A write sets an internal register pointer from the first byte after the address. Each following byte goes to the register at the pointer, and the pointer then steps forward. A read uses a repeated START, or a fresh START, with the read address. It returns the register at the pointer and then each following register for as long as the host acknowledges. Sixteen read/write configuration registers (indices 0x00 to 0x0F) hold power-on defaults and also appear in parallel on an output bus. Three read-only registers (0x10 to 0x12) are fed from input ports. Bit 7 of register 0x11 is a sticky power-on flag that is set by reset and cleared by reading that register.

The controller has ten named states:
- IDLE: waits for START.
- ADDR: shifts in the address byte.
- ADDR_ACK: drives the address acknowledge.
- PTR and PTR_ACK: receive and acknowledge the pointer byte.
- WDATA and WDATA_ACK: receive and acknowledge data bytes.
- RDATA: shifts out a register.
- RACK: samples the host's acknowledge.
- IGNORE: waits out a transaction that is not for this slave.

The transitions are:
- START from any state goes to ADDR. STOP from any state goes to IDLE.
- ADDR goes to ADDR_ACK on an address match, or to IGNORE on a mismatch.
- ADDR_ACK goes to PTR for a write, or to RDATA for a read.
- PTR goes to PTR_ACK, and PTR_ACK goes to WDATA.
- WDATA and WDATA_ACK alternate.
- RDATA goes to RACK. RACK goes back to RDATA on an ACK, or to IGNORE on a NACK.

Top module: `tuner_i2c_regfile`

## Requirements
- R1: The slave answers only the 7-bit address {1,1,0,0,0,S,0}, where S is `addr_sel`. The write/read address bytes are C0h/C1h when S=0 and C4h/C5h when S=1. Any other address byte is not acknowledged, and all later bytes of that transaction are neither acknowledged nor stored, until the next START or STOP.
- R2: After reset, registers 0x00 to 0x0F hold 17h, 18h, 00h, 00h, DBh, 7Ch, 0Ah, 08h, 00h, C0h, 87h, 38h, 00h, 00h, 00h and 00h, in index order. Register i appears on `cfg_o[8*i+7:8*i]`.
- R3: In a write, the byte after the address sets the pointer. Each further byte is acknowledged, stored at the pointer (if the pointer is below 0x10), and the pointer then advances. Any number of bytes may follow, until STOP.
- R4: A read returns the register at the pointer, MSB first, and then consecutive registers while the host ACKs. After a host NACK the slave drives SDA for no further bit until the next START.
- R5: A write to indices 0x10 to 0x12 is acknowledged but discarded, and the pointer still advances. Reads of 0x10 and 0x12 return `fuse_rd_i` and `tune_rd_i`.
- R6: The pointer advances from 0x12 to 0x00. A pointer above 0x12 reads as 00h, ignores writes and advances to 0x00.
- R7: Register 0x11 reads as {power-on flag, `status_i[6:0]`}.
- R8: The power-on flag reads 1 on the first read of 0x11 after reset. It reads 0 on every later read until the next reset.
- R9: For `HOLDOFF_CYCLES` clocks after reset (100 µs at 50 MHz), the slave ignores the bus and never drives SDA.
- R10: A STOP in the middle of a byte discards the partial byte and returns to IDLE. A START in any state begins a new address phase.
- R11: An SCL pulse one clock long does not count as a bus clock.
- R12: SDA is driven low only during an acknowledge or a read data bit, and the drive changes only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-on) |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_drive_low | output | 1 | 1 pulls SDA low; 0 releases it |
| addr_sel | input | 1 | Strap selecting address bit 2 |
| fuse_rd_i | input | 8 | Contents of read-only register 0x10 |
| status_i | input | 7 | Bits 6:0 of read-only register 0x11 |
| tune_rd_i | input | 8 | Contents of read-only register 0x12 |
| cfg_o | output | 128 | Registers 0x00 to 0x0F, register i in bits 8i+7:8i |

## Verification
The bench aims at these corner cases:
- **Pointer across the read-only window and the wrap.** A six-byte write from 0x0E lands its last byte in 0x00. A design that stalls the pointer on read-only writes would instead put it in 0x10, and a design that does not wrap would drop it.
- **Power-on flag on repeated reads.** Register 0x11 is read twice. A flag that is never cleared, or one cleared by some other access, shows the wrong bit 7 on one of the two reads.
- **Wrong address, strap change and hold-off window.** A design that snoops data after a mismatch would alter a register. A design that ignores the strap would answer C0h when it should answer C4h. A design without the hold-off window would acknowledge right after reset.
- **Mid-byte STOP, SCL glitches and clocks after a NACK.** STOP arrives mid-byte, one-clock SCL glitches are inserted, and extra clocks follow a NACK. A design that shifts on glitches corrupts data, and one that keeps transmitting after a NACK pulls SDA low.

// File: rtl/tif_pkg.sv
package tif_pkg;

    localparam int BYTE_W  = 8;
    localparam int NUM_RO  = 3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } tif_state_e;

    // Power-on contents of the read/write configuration registers
    function automatic logic [BYTE_W-1:0] reg_default(input int unsigned idx);
        logic [BYTE_W-1:0] v;
        case (idx)
            0:       v = 8'h17;
            1:       v = 8'h18;
            4:       v = 8'hDB;
            5:       v = 8'h7C;
            6:       v = 8'h0A;
            7:       v = 8'h08;
            9:       v = 8'hC0;
            10:      v = 8'h87;
            11:      v = 8'h38;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/tif_line_filter.sv
module tif_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int VOTE_TAPS   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int MAJORITY = VOTE_TAPS / 2 + 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [VOTE_TAPS-1:0]   win_q;
    logic                   vote_d;

    always_comb begin
        int ones;
        ones = 0;
        for (int i = 0; i < VOTE_TAPS; i++) begin
            ones = ones + int'(win_q[i]);
        end
        vote_d = (ones >= MAJORITY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q  <= '1;
            win_q   <= '1;
            clean_o <= 1'b1;
        end else begin
            sync_q  <= {sync_q[SYNC_STAGES-2:0], raw_i};
            win_q   <= {win_q[VOTE_TAPS-2:0], sync_q[SYNC_STAGES-1]};
            clean_o <= vote_d;
        end
    end
endmodule

// File: rtl/tif_bus_events.sv
module tif_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_c,
    input  logic sda_c,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_c;
            sda_q <= sda_c;
        end
    end

    always_comb begin
        scl_rise  = scl_c & ~scl_q;
        scl_fall  = ~scl_c & scl_q;
        start_evt = scl_c & scl_q & sda_q & ~sda_c;
        stop_evt  = scl_c & scl_q & ~sda_q & sda_c;
    end
endmodule

// File: rtl/tif_reg_bank.sv
module tif_reg_bank
    import tif_pkg::*;
#(
    parameter int NUM_RW = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [BYTE_W-1:0]        wr_idx,
    input  logic [BYTE_W-1:0]        wr_data,
    input  logic                     rd_en,
    input  logic [BYTE_W-1:0]        rd_idx,
    output logic [BYTE_W-1:0]        rd_data,
    input  logic [BYTE_W-1:0]        fuse_rd_i,
    input  logic [6:0]               status_i,
    input  logic [BYTE_W-1:0]        tune_rd_i,
    output logic [NUM_RW*BYTE_W-1:0] cfg_o,
    output logic                     por_o
);
    localparam int                IDX_W    = $clog2(NUM_RW);
    localparam logic [BYTE_W-1:0] RO_FUSE  = BYTE_W'(NUM_RW);
    localparam logic [BYTE_W-1:0] RO_STAT  = BYTE_W'(NUM_RW + 1);
    localparam logic [BYTE_W-1:0] RO_TUNE  = BYTE_W'(NUM_RW + 2);
    localparam logic [BYTE_W-1:0] RW_LIMIT = BYTE_W'(NUM_RW);

    logic [BYTE_W-1:0] rw_q [NUM_RW];
    logic              por_q;

    for (genvar g = 0; g < NUM_RW; g++) begin : g_rw
        localparam logic [BYTE_W-1:0] MY_IDX = BYTE_W'(g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rw_q[g] <= reg_default(g);
            end else if (wr_en && wr_idx == MY_IDX) begin
                rw_q[g] <= wr_data;
            end
        end
        assign cfg_o[g*BYTE_W +: BYTE_W] = rw_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            por_q <= 1'b1;
        end else if (rd_en && rd_idx == RO_STAT) begin
            por_q <= 1'b0;
        end
    end

    always_comb begin
        if (rd_idx < RW_LIMIT) begin
            rd_data = rw_q[rd_idx[IDX_W-1:0]];
        end else if (rd_idx == RO_FUSE) begin
            rd_data = fuse_rd_i;
        end else if (rd_idx == RO_STAT) begin
            rd_data = {por_q, status_i};
        end else if (rd_idx == RO_TUNE) begin
            rd_data = tune_rd_i;
        end else begin
            rd_data = '0;
        end
    end

    assign por_o = por_q;
endmodule

// File: rtl/tuner_i2c_regfile.sv
module tuner_i2c_regfile
    import tif_pkg::*;
#(
    parameter int HOLDOFF_CYCLES = 5000,
    parameter int SYNC_STAGES    = 2,
    parameter int VOTE_TAPS      = 3,
    parameter int NUM_RW         = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     scl_i,
    input  logic                     sda_i,
    output logic                     sda_drive_low,
    input  logic                     addr_sel,
    input  logic [7:0]               fuse_rd_i,
    input  logic [6:0]               status_i,
    input  logic [7:0]               tune_rd_i,
    output logic [NUM_RW*8-1:0]      cfg_o
);
    localparam int                NUM_REGS = NUM_RW + NUM_RO;
    localparam logic [BYTE_W-1:0] LAST_IDX = BYTE_W'(NUM_REGS - 1);
    localparam int                HO_W     = $clog2(HOLDOFF_CYCLES + 1);
    localparam logic [HO_W-1:0]   HO_LAST  = HO_W'(HOLDOFF_CYCLES - 1);

    logic scl_c, sda_c;
    logic scl_rise, scl_fall, start_evt, stop_evt;

    tif_state_e        state_q, state_d;
    logic [3:0]        bitcnt_q;
    logic [BYTE_W-1:0] shreg_q, txsh_q, ptr_q, ptr_next;
    logic              mack_q;
    logic [HO_W-1:0]   ho_cnt_q;
    logic              ready_q;

    logic              rx_state, byte_done, addr_hit, load_rd, wr_en;
    logic [BYTE_W-1:0] rd_data;
    logic              por_flag;

    tif_line_filter #(.SYNC_STAGES(SYNC_STAGES), .VOTE_TAPS(VOTE_TAPS)) u_scl_filt (
        .clk(clk), .rst_n(rst_n), .raw_i(scl_i), .clean_o(scl_c)
    );
    tif_line_filter #(.SYNC_STAGES(SYNC_STAGES), .VOTE_TAPS(VOTE_TAPS)) u_sda_filt (
        .clk(clk), .rst_n(rst_n), .raw_i(sda_i), .clean_o(sda_c)
    );

    tif_bus_events u_events (
        .clk(clk), .rst_n(rst_n), .scl_c(scl_c), .sda_c(sda_c),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    tif_reg_bank #(.NUM_RW(NUM_RW)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(ptr_q), .wr_data(shreg_q),
        .rd_en(load_rd), .rd_idx(ptr_q), .rd_data(rd_data),
        .fuse_rd_i(fuse_rd_i), .status_i(status_i), .tune_rd_i(tune_rd_i),
        .cfg_o(cfg_o), .por_o(por_flag)
    );

    // Power-up hold-off: bus is ignored until the counter expires
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ho_cnt_q <= '0;
            ready_q  <= 1'b0;
        end else if (!ready_q) begin
            if (ho_cnt_q == HO_LAST) begin
                ready_q <= 1'b1;
            end else begin
                ho_cnt_q <= ho_cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        rx_state  = (state_q == ST_ADDR) || (state_q == ST_PTR) || (state_q == ST_WDATA);
        byte_done = rx_state && scl_fall && (bitcnt_q == 4'd8);
        addr_hit  = (shreg_q[7:1] == {5'b11000, addr_sel, 1'b0});
        load_rd   = ((state_q == ST_ADDR_ACK) && scl_fall && shreg_q[0]) ||
                    ((state_q == ST_RACK) && scl_fall && mack_q);
        wr_en     = (state_q == ST_WDATA) && byte_done;
        ptr_next  = (ptr_q >= LAST_IDX) ? '0 : ptr_q + 1'b1;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!ready_q) begin
            state_d = ST_IDLE;
        end else if (start_evt) begin
            state_d = ST_ADDR;
        end else if (stop_evt) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_ADDR:      if (byte_done) state_d = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:  if (scl_fall) state_d = shreg_q[0] ? ST_RDATA : ST_PTR;
                ST_PTR:       if (byte_done) state_d = ST_PTR_ACK;
                ST_PTR_ACK:   if (scl_fall) state_d = ST_WDATA;
                ST_WDATA:     if (byte_done) state_d = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) state_d = ST_WDATA;
                ST_RDATA:     if (scl_fall && bitcnt_q == 4'd7) state_d = ST_RACK;
                ST_RACK:      if (scl_fall) state_d = mack_q ? ST_RDATA : ST_IGNORE;
                ST_IGNORE:    state_d = ST_IGNORE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Shift, count and pointer datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt_q <= '0;
            shreg_q  <= '0;
            txsh_q   <= '0;
            ptr_q    <= '0;
            mack_q   <= 1'b0;
        end else if (!ready_q || start_evt || stop_evt) begin
            bitcnt_q <= '0;
        end else begin
            if (rx_state && scl_rise) begin
                shreg_q  <= {shreg_q[6:0], sda_c};
                bitcnt_q <= bitcnt_q + 1'b1;
            end
            if (byte_done) begin
                bitcnt_q <= '0;
            end
            if ((state_q == ST_PTR) && byte_done) begin
                ptr_q <= shreg_q;
            end
            if (wr_en) begin
                ptr_q <= ptr_next;
            end
            if (load_rd) begin
                txsh_q   <= rd_data;
                ptr_q    <= ptr_next;
                bitcnt_q <= '0;
            end
            if ((state_q == ST_RDATA) && scl_fall) begin
                if (bitcnt_q == 4'd7) begin
                    bitcnt_q <= '0;
                end else begin
                    txsh_q   <= {txsh_q[6:0], 1'b0};
                    bitcnt_q <= bitcnt_q + 1'b1;
                end
            end
            if ((state_q == ST_RACK) && scl_rise) begin
                mack_q <= ~sda_c;
            end
        end
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            ST_ADDR_ACK,
            ST_PTR_ACK,
            ST_WDATA_ACK: sda_drive_low = 1'b1;
            ST_RDATA:     sda_drive_low = ~txsh_q[7];
            default:      sda_drive_low = 1'b0;
        endcase
    end
endmodule

// File: rtl/tif_checker.sv
module tif_checker
    import tif_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       ready,
    input logic       scl_c,
    input logic       start_evt,
    input logic       stop_evt,
    input tif_state_e state,
    input logic       sda_drive_low,
    input logic       por_flag
);
    AST_HOLDOFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !sda_drive_low); // R9

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && stop_evt) |=> state == ST_IDLE); // R10

    AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && start_evt) |=> state == ST_ADDR); // R10

    AST_DRIVE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        sda_drive_low |-> (state == ST_ADDR_ACK || state == ST_PTR_ACK ||
                           state == ST_WDATA_ACK || state == ST_RDATA)); // R12

    AST_DRIVE_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_c && $past(scl_c)) |-> $stable(sda_drive_low)); // R12

    AST_HOST_ACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RACK || state == ST_IGNORE) |-> !sda_drive_low); // R4

    AST_POR_STICKY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !por_flag |=> !por_flag); // R8
endmodule

bind tuner_i2c_regfile tif_checker u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .ready(ready_q),
    .scl_c(scl_c),
    .start_evt(start_evt),
    .stop_evt(stop_evt),
    .state(state_q),
    .sda_drive_low(sda_drive_low),
    .por_flag(por_flag)
);

// File: tb/sim_tuner_i2c_regfile.sv
`timescale 1ns/1ps
module sim_tuner_i2c_regfile;
    localparam int Q     = 6;
    localparam int HOLD  = 5000;
    localparam logic [7:0] FUSE = 8'h5A;
    localparam logic [6:0] STAT = 7'h2B;
    localparam logic [7:0] TUNE = 8'hC3;

    // {pointer, write data, expected readback}
    localparam logic [23:0] VEC [0:7] = '{
        24'h00A5A5, 24'h073C3C, 24'h0FFFFF, 24'h10555A,
        24'h1266C3, 24'h050000, 24'h0B8181, 24'h147700
    };

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic         rst_n = 1'b0;
    logic         m_scl = 1'b1;
    logic         m_sda_low = 1'b0;
    logic         strap = 1'b0;
    logic         glitch_en = 1'b0;
    logic         sda_drive_low;
    logic [127:0] cfg_o;
    wire          sda_line = ~(m_sda_low | sda_drive_low);

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [7:0] wbuf [0:31];
    logic [7:0] rbuf [0:31];

    tuner_i2c_regfile u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .sda_drive_low(sda_drive_low), .addr_sel(strap),
        .fuse_rd_i(FUSE), .status_i(STAT), .tune_rd_i(TUNE), .cfg_o(cfg_o)
    );

    function automatic logic [7:0] exp_default(input int i);
        case (i)
            0: return 8'h17;  1: return 8'h18;  4: return 8'hDB;  5: return 8'h7C;
            6: return 8'h0A;  7: return 8'h08;  9: return 8'hC0; 10: return 8'h87;
            11: return 8'h38;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bit(input logic low, output logic smp);
        m_scl = 1'b0;
        wt(Q);
        if (glitch_en) begin
            m_scl = 1'b1; wt(1); m_scl = 1'b0;
        end
        m_sda_low = low;
        wt(Q);
        m_scl = 1'b1;
        wt(Q);
        smp = sda_line;
        wt(Q);
    endtask

    task automatic bus_start();
        m_scl = 1'b0; wt(Q);
        m_sda_low = 1'b0; wt(Q);
        m_scl = 1'b1; wt(2*Q);
        m_sda_low = 1'b1; wt(2*Q);
    endtask

    task automatic bus_stop();
        m_scl = 1'b0; wt(Q);
        m_sda_low = 1'b1; wt(Q);
        m_scl = 1'b1; wt(2*Q);
        m_sda_low = 1'b0; wt(2*Q);
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(~b[i], s);
        clk_bit(1'b0, s);
        ack = ~s;
    endtask

    task automatic rbyte(input logic host_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b0, s);
            b[i] = s;
        end
        clk_bit(host_ack, s);
    endtask

    function automatic logic [7:0] aw();
        return strap ? 8'hC4 : 8'hC0;
    endfunction

    task automatic write_regs(input logic [7:0] ptr, input int n);
        logic a;
        bus_start();
        wbyte(aw(), a);
        wbyte(ptr, a);
        for (int i = 0; i < n; i++) wbyte(wbuf[i], a);
        bus_stop();
    endtask

    task automatic read_regs(input logic [7:0] ptr, input int n);
        logic a;
        logic [7:0] b;
        bus_start();
        wbyte(aw(), a);
        wbyte(ptr, a);
        bus_start();
        wbyte(aw() | 8'h01, a);
        for (int i = 0; i < n; i++) begin
            rbyte(i != n - 1, b);
            rbuf[i] = b;
        end
        bus_stop();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic a;
        logic s;
        logic [7:0] b;
        int highs;

        wt(3);
        rst_n = 1'b1;
        wt(2);

        // Reset state: defaults on the parallel bus, SDA released
        for (int i = 0; i < 16; i++) chk("R2 reset default", cfg_o[i*8 +: 8], exp_default(i));
        chk("R12 released after reset", sda_drive_low, 1'b0);

        // Hold-off: no acknowledge right after reset
        bus_start();
        wbyte(8'hC0, a);
        chk("R9 no ack during hold-off", a, 1'b0);
        bus_stop();
        wt(HOLD);

        // Burst read of all defaults
        read_regs(8'h00, 16);
        for (int i = 0; i < 16; i++) chk("R2 R4 burst read default", rbuf[i], exp_default(i));

        // Power-on flag
        read_regs(8'h11, 1);
        chk("R8 first status read", rbuf[0], {1'b1, STAT});
        read_regs(8'h11, 1);
        chk("R7 R8 second status read", rbuf[0], {1'b0, STAT});

        // Vector table: single write then readback
        for (int v = 0; v < 8; v++) begin
            wbuf[0] = VEC[v][15:8];
            write_regs(VEC[v][23:16], 1);
            read_regs(VEC[v][23:16], 1);
            if (VEC[v][23:16] < 8'h10)      chk("R3 table readback", rbuf[0], VEC[v][7:0]);
            else if (VEC[v][23:16] < 8'h13) chk("R5 table readback", rbuf[0], VEC[v][7:0]);
            else                            chk("R6 table readback", rbuf[0], VEC[v][7:0]);
        end

        // Multi-byte write through read-only window and wrap
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        wbuf[3] = 8'h44; wbuf[4] = 8'h55; wbuf[5] = 8'h66;
        write_regs(8'h0E, 6);
        chk("R6 wrap write to 0x00", cfg_o[7:0], 8'h66);
        read_regs(8'h0E, 6);
        chk("R3 burst 0x0E", rbuf[0], 8'h11);
        chk("R3 burst 0x0F", rbuf[1], 8'h22);
        chk("R5 burst 0x10", rbuf[2], FUSE);
        chk("R5 burst 0x11", rbuf[3], {1'b0, STAT});
        chk("R5 burst 0x12", rbuf[4], TUNE);
        chk("R6 burst wrap 0x00", rbuf[5], 8'h66);

        // Wrong address with strap 0
        bus_start();
        wbyte(8'hC4, a); chk("R1 foreign address nack", a, 1'b0);
        wbyte(8'h03, a); chk("R1 ignored pointer", a, 1'b0);
        wbyte(8'hEE, a); chk("R1 ignored data", a, 1'b0);
        bus_stop();
        chk("R1 register untouched", cfg_o[3*8 +: 8], 8'h00);

        // Strap 1
        strap = 1'b1;
        wt(10);
        bus_start();
        wbyte(8'hC4, a); chk("R1 strap address ack", a, 1'b1);
        wbyte(8'h03, a);
        wbyte(8'h9C, a);
        bus_stop();
        bus_start();
        wbyte(8'hC0, a); chk("R1 old address nack", a, 1'b0);
        bus_stop();
        read_regs(8'h03, 1);
        chk("R1 strap readback", rbuf[0], 8'h9C);
        strap = 1'b0;
        wt(10);

        // SCL glitches during a data byte
        bus_start();
        wbyte(8'hC0, a);
        wbyte(8'h09, a);
        glitch_en = 1'b1;
        wbyte(8'h5E, a);
        glitch_en = 1'b0;
        chk("R11 ack with glitches", a, 1'b1);
        bus_stop();
        read_regs(8'h09, 1);
        chk("R11 glitch-free data", rbuf[0], 8'h5E);

        // STOP in the middle of a byte
        bus_start();
        wbyte(8'hC0, a);
        wbyte(8'h0C, a);
        for (int i = 0; i < 4; i++) clk_bit(1'b0, s);
        bus_stop();
        chk("R10 partial byte discarded", cfg_o[12*8 +: 8], 8'h00);
        read_regs(8'h0C, 1);
        chk("R10 next transaction works", rbuf[0], 8'h00);

        // NACK then extra clocks: slave must stay off the line
        bus_start();
        wbyte(8'hC0, a);
        wbyte(8'h00, a);
        bus_start();
        wbyte(8'hC1, a);
        rbyte(1'b0, b);
        chk("R4 first byte before nack", b, 8'h66);
        highs = 0;
        for (int i = 0; i < 9; i++) begin
            clk_bit(1'b0, s);
            highs += int'(s);
        end
        chk("R4 released after nack", highs, 9);
        bus_stop();
        chk("R12 released after stop", sda_drive_low, 1'b0);

        finish_run();
    end
endmodule